// File: doc/BRIEF.md
# Processor Sideband Control Generator

This block drives the legacy control and power-state sideband wires that run from a platform controller to a processor. It produces the address-bit-20 mask, a fixed-length active-low processor reset pulse and an identical copy of that pulse for a firmware-store power domain. It also drives a regulator deep-sleep select with an active-low twin, and an active-low processor sleep request tied to the shallow system sleep state.

A battery-low input is brought into the clock domain through a synchronizer. While it is asserted, it blocks wake requests out of the deep system sleep states. When enabled, it raises a single-cycle management-interrupt request on its rising edge. Software reaches the block through a small register-write port. Bit 0 of the write data is the stored mask bit. Bit 1 of the write data is a self-clearing request for a reset pulse.

Top module: `cpu_sideband_gen`

## Requirements
- R1: `a20_mask_o` is the OR of the stored mask bit and `a20_gate_i`, with no clock delay (default variant). The stored mask bit takes the value of `reg_wdata[0]` at each clock edge where `reg_wr` is high.
- R2: A write with `reg_wdata[1]`=1 drives `init_n_o` low from the next cycle for exactly INIT_CYCLES (default 16) cycles. After that, `init_n_o` returns high.
- R3: `init_fw_n_o` equals `init_n_o` in every cycle.
- R4: `vr_deep_o` is high one cycle after `cstate_i` equals DEEP_CSTATE (default 4, the plain C-state number). It is low one cycle after any other value.
- R5: `deep_stop_n_o` is the inverse of `vr_deep_o` in every cycle.
- R6: `wake_o` is `wake_req_i` delayed by one cycle. It is forced low when the synchronized battery-low is high and `sstate_i` is 3, 4 or 5. In the other sleep states it passes unchanged.
- R7: With `smi_en_i` high, a rise of `batt_low_i` produces a `smi_req_o` pulse one cycle long. The pulse comes SYNC_STAGES+1 cycles after the input changes, which is 3 at the default. With `smi_en_i` low, no pulse is produced.
- R8: `cpu_slp_n_o` is low one cycle after `sstate_i`=1 with `slp_en_i` high. In every other case it is high.
- R9: A reset-pulse request made while a pulse is running reloads the count. `init_n_o` then stays low for exactly INIT_CYCLES cycles counted from the new request.
- R10: While `rst_n` is low, every output is deasserted: `init_n_o`, `init_fw_n_o`, `deep_stop_n_o` and `cpu_slp_n_o` high, the others low (with `a20_gate_i` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Bit 0: mask bit value; bit 1: reset-pulse request |
| a20_gate_i | input | 1 | External address-20 gate |
| cstate_i | input | 3 | Current processor C-state number |
| sstate_i | input | 3 | Current system S-state number |
| slp_en_i | input | 1 | Enable for sleep request in S1 |
| smi_en_i | input | 1 | Enable for interrupt on battery-low |
| batt_low_i | input | 1 | Asynchronous battery-low indication |
| wake_req_i | input | 1 | Raw wake request |
| a20_mask_o | output | 1 | Address-bit-20 mask, active high |
| init_n_o | output | 1 | Processor reset pulse, active low |
| init_fw_n_o | output | 1 | Copy of the reset pulse for the firmware store |
| vr_deep_o | output | 1 | Regulator deep-sleep select |
| deep_stop_n_o | output | 1 | Active-low twin of the deep-sleep select |
| cpu_slp_n_o | output | 1 | Processor sleep request, active low |
| wake_o | output | 1 | Gated wake request |
| smi_req_o | output | 1 | Management-interrupt request pulse |

## Verification
The assertions assume that `smi_en_i`, `slp_en_i`, `cstate_i` and `sstate_i` are synchronous to `clk`. They also assume that only `batt_low_i` arrives from another domain, so the one-cycle relations hold at each edge. The stimulus changes every input on the falling edge. It holds `batt_low_i` steady for more cycles than the synchronizer depth before it tests wake blocking, so the synchronized level is settled when each check is made.

// File: rtl/sbg_pkg.sv
`timescale 1ns/1ps
package sbg_pkg;
   // Registered power-state outputs, kept together.
   typedef struct packed {
      logic vr_deep;
      logic slp;
   } pwr_flags_t;

   function automatic logic in_range(input logic [7:0] v, input logic [7:0] lo,
                                     input logic [7:0] hi);
      return (v >= lo) && (v <= hi);
   endfunction
endpackage

// File: rtl/sbg_a20_mask.sv
`timescale 1ns/1ps
module sbg_a20_mask #(
   parameter bit MASK_REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wbit,
   input  logic gate,
   output logic mask
);
   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bit_q <= 1'b0;
      else if (wr) bit_q <= wbit;
   end

   generate
      if (MASK_REG_OUT) begin : g_reg
         logic mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q <= 1'b0;
            else        mask_q <= bit_q | gate;
         end
         assign mask = mask_q;
      end else begin : g_comb
         assign mask = bit_q | gate;
      end
   endgenerate
endmodule

// File: rtl/sbg_init_pulse.sv
`timescale 1ns/1ps
module sbg_init_pulse #(
   parameter int INIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic init_n,
   output logic init_fw_n
);
   localparam int CNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(INIT_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (req)            cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign init_n    = (cnt_q == '0);
   assign init_fw_n = init_n;
endmodule

// File: rtl/sbg_pwr_state.sv
`timescale 1ns/1ps
module sbg_pwr_state
   import sbg_pkg::*;
#(
   parameter int CST_W        = 3,
   parameter int SST_W        = 3,
   parameter int DEEP_CSTATE  = 4,
   parameter int SLEEP_SSTATE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CST_W-1:0] cstate,
   input  logic [SST_W-1:0] sstate,
   input  logic             slp_en,
   output logic             vr_deep,
   output logic             deep_stop_n,
   output logic             slp_n
);
   localparam logic [CST_W-1:0] DEEP_C = CST_W'(DEEP_CSTATE);
   localparam logic [SST_W-1:0] SLP_S  = SST_W'(SLEEP_SSTATE);

   pwr_flags_t fl_q, fl_d;

   always_comb begin
      fl_d.vr_deep = (cstate == DEEP_C);
      fl_d.slp     = slp_en && (sstate == SLP_S);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fl_q <= '0;
      else        fl_q <= fl_d;
   end

   assign vr_deep     = fl_q.vr_deep;
   assign deep_stop_n = ~fl_q.vr_deep;
   assign slp_n       = ~fl_q.slp;
endmodule

// File: rtl/sbg_batt_mon.sv
`timescale 1ns/1ps
module sbg_batt_mon
   import sbg_pkg::*;
#(
   parameter int SST_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int BLK_LO      = 3,
   parameter int BLK_HI      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             batt_low,
   input  logic             smi_en,
   input  logic [SST_W-1:0] sstate,
   input  logic             wake_req,
   output logic             wake,
   output logic             smi_req
);
   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q, smi_q, wake_q, bl_s, deep_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], batt_low};
   end
   assign bl_s = sh_q[SYNC_STAGES-1];

   assign deep_s = in_range(8'(sstate), 8'(BLK_LO), 8'(BLK_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         smi_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         prev_q <= bl_s;
         smi_q  <= smi_en & bl_s & ~prev_q;
         wake_q <= wake_req & ~(bl_s & deep_s);
      end
   end

   assign wake    = wake_q;
   assign smi_req = smi_q;
endmodule

// File: rtl/cpu_sideband_gen.sv
`timescale 1ns/1ps
module cpu_sideband_gen #(
   parameter int INIT_CYCLES  = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int CST_W        = 3,
   parameter int SST_W        = 3,
   parameter int DEEP_CSTATE  = 4,
   parameter int SLEEP_SSTATE = 1,
   parameter int BLK_LO       = 3,
   parameter int BLK_HI       = 5,
   parameter bit MASK_REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_wdata,
   input  logic             a20_gate_i,
   input  logic [CST_W-1:0] cstate_i,
   input  logic [SST_W-1:0] sstate_i,
   input  logic             slp_en_i,
   input  logic             smi_en_i,
   input  logic             batt_low_i,
   input  logic             wake_req_i,
   output logic             a20_mask_o,
   output logic             init_n_o,
   output logic             init_fw_n_o,
   output logic             vr_deep_o,
   output logic             deep_stop_n_o,
   output logic             cpu_slp_n_o,
   output logic             wake_o,
   output logic             smi_req_o
);
   // Elaboration-time parameter checks
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEEP_CSTATE >= (1 << CST_W)) begin : g_bad_deep
      $error("DEEP_CSTATE does not fit CST_W");
   end
   if (BLK_LO > BLK_HI || BLK_HI >= (1 << SST_W)) begin : g_bad_blk
      $error("wake block range invalid");
   end

   logic init_req;
   assign init_req = reg_wr & reg_wdata[1];

   sbg_a20_mask #(.MASK_REG_OUT(MASK_REG_OUT)) u_a20 (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wbit(reg_wdata[0]),
      .gate(a20_gate_i), .mask(a20_mask_o));

   sbg_init_pulse #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .req(init_req),
      .init_n(init_n_o), .init_fw_n(init_fw_n_o));

   sbg_pwr_state #(.CST_W(CST_W), .SST_W(SST_W), .DEEP_CSTATE(DEEP_CSTATE),
                   .SLEEP_SSTATE(SLEEP_SSTATE)) u_pwr (
      .clk(clk), .rst_n(rst_n), .cstate(cstate_i), .sstate(sstate_i),
      .slp_en(slp_en_i), .vr_deep(vr_deep_o), .deep_stop_n(deep_stop_n_o),
      .slp_n(cpu_slp_n_o));

   sbg_batt_mon #(.SST_W(SST_W), .SYNC_STAGES(SYNC_STAGES), .BLK_LO(BLK_LO),
                  .BLK_HI(BLK_HI)) u_batt (
      .clk(clk), .rst_n(rst_n), .batt_low(batt_low_i), .smi_en(smi_en_i),
      .sstate(sstate_i), .wake_req(wake_req_i), .wake(wake_o),
      .smi_req(smi_req_o));
endmodule

// File: rtl/sbg_checker.sv
`timescale 1ns/1ps
module sbg_checker #(
   parameter int INIT_CYCLES  = 16,
   parameter int CST_W        = 3,
   parameter int DEEP_CSTATE  = 4,
   parameter bit MASK_REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_wdata,
   input logic             a20_gate_i,
   input logic [CST_W-1:0] cstate_i,
   input logic             slp_en_i,
   input logic             smi_en_i,
   input logic             wake_req_i,
   input logic             a20_mask_o,
   input logic             init_n_o,
   input logic             init_fw_n_o,
   input logic             vr_deep_o,
   input logic             deep_stop_n_o,
   input logic             cpu_slp_n_o,
   input logic             wake_o,
   input logic             smi_req_o
);
   localparam int LW = $clog2(INIT_CYCLES + 2) + 1;
   logic [LW-1:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_len <= '0;
      else if (reg_wr && reg_wdata[1])  low_len <= LW'(1);
      else if (!init_n_o)               low_len <= low_len + 1'b1;
      else                              low_len <= '0;
   end

   AST_A20_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!MASK_REG_OUT && a20_gate_i) |-> a20_mask_o); // R1
   AST_INIT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[1]) |=> !init_n_o); // R2
   AST_INIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      !init_n_o |-> (low_len <= LW'(INIT_CYCLES))); // R9
   AST_INIT_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
      init_fw_n_o == init_n_o); // R3
   AST_VR_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cstate_i == CST_W'(DEEP_CSTATE)) |=> vr_deep_o); // R4
   AST_DEEP_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
      deep_stop_n_o != vr_deep_o); // R5
   AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_req_i |=> !wake_o); // R6
   AST_SMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req_o |=> !smi_req_o); // R7
   AST_SMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !smi_en_i |=> !smi_req_o); // R7
   AST_SLP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !slp_en_i |=> cpu_slp_n_o); // R8
endmodule

bind cpu_sideband_gen sbg_checker #(
   .INIT_CYCLES(INIT_CYCLES), .CST_W(CST_W), .DEEP_CSTATE(DEEP_CSTATE),
   .MASK_REG_OUT(MASK_REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .a20_gate_i(a20_gate_i), .cstate_i(cstate_i), .slp_en_i(slp_en_i),
   .smi_en_i(smi_en_i), .wake_req_i(wake_req_i), .a20_mask_o(a20_mask_o),
   .init_n_o(init_n_o), .init_fw_n_o(init_fw_n_o), .vr_deep_o(vr_deep_o),
   .deep_stop_n_o(deep_stop_n_o), .cpu_slp_n_o(cpu_slp_n_o),
   .wake_o(wake_o), .smi_req_o(smi_req_o));

// File: tb/sim_cpu_sideband_gen.sv
`timescale 1ns/1ps
module sim_cpu_sideband_gen;
   localparam int INIT_CYCLES = 16;
   localparam int SYNC_STAGES = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_wdata = '0;
   logic a20_gate_i = 1'b0, slp_en_i = 1'b0, smi_en_i = 1'b0;
   logic batt_low_i = 1'b0, wake_req_i = 1'b0;
   logic [2:0] cstate_i = '0, sstate_i = '0;
   logic a20_mask_o, init_n_o, init_fw_n_o, vr_deep_o, deep_stop_n_o;
   logic cpu_slp_n_o, wake_o, smi_req_o;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cpu_sideband_gen #(.INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .a20_gate_i(a20_gate_i), .cstate_i(cstate_i), .sstate_i(sstate_i),
      .slp_en_i(slp_en_i), .smi_en_i(smi_en_i), .batt_low_i(batt_low_i),
      .wake_req_i(wake_req_i), .a20_mask_o(a20_mask_o), .init_n_o(init_n_o),
      .init_fw_n_o(init_fw_n_o), .vr_deep_o(vr_deep_o),
      .deep_stop_n_o(deep_stop_n_o), .cpu_slp_n_o(cpu_slp_n_o),
      .wake_o(wake_o), .smi_req_o(smi_req_o));

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   // Count low samples of the reset pulse and check the twin each cycle.
   task automatic count_low(output int n);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         if (!init_n_o) n++;
         chk("R3 twin", int'(init_fw_n_o), int'(init_n_o));
         step();
      end
   endtask

   initial begin
      int lowc, hits, idx;
      step(3);
      // R10: reset values
      chk("R10 a20", a20_mask_o, 0);
      chk("R10 init", init_n_o, 1);
      chk("R10 init_fw", init_fw_n_o, 1);
      chk("R10 vr", vr_deep_o, 0);
      chk("R10 dstop", deep_stop_n_o, 1);
      chk("R10 slp", cpu_slp_n_o, 1);
      chk("R10 wake", wake_o, 0);
      chk("R10 smi", smi_req_o, 0);
      rst_n = 1'b1;
      step(2);

      // R1: sweep mask bit x gate
      for (int m = 0; m < 2; m++) begin
         for (int g = 0; g < 2; g++) begin
            write_reg(2'(m));
            a20_gate_i = 1'(g);
            #1;
            chk("R1 a20", a20_mask_o, m | g);
         end
      end
      write_reg(2'b00);
      a20_gate_i = 1'b0;
      #1 chk("R1 a20 clear", a20_mask_o, 0);

      // R2/R3: single pulse length
      write_reg(2'b10);
      count_low(lowc);
      chk("R2 pulse length", lowc, INIT_CYCLES);

      // R9: restart in mid pulse
      write_reg(2'b10);
      step(5);
      chk("R9 low before restart", init_n_o, 0);
      write_reg(2'b10);
      count_low(lowc);
      chk("R9 restart length", lowc, INIT_CYCLES);

      // R4/R5: sweep all C-states
      for (int c = 0; c < 8; c++) begin
         cstate_i = 3'(c);
         step();
         chk("R4 vr_deep", vr_deep_o, (c == 4) ? 1 : 0);
         chk("R5 deep_stop_n", deep_stop_n_o, (c == 4) ? 0 : 1);
      end
      cstate_i = '0;

      // R8: sweep S-states x enable
      for (int e = 0; e < 2; e++) begin
         for (int s = 0; s < 8; s++) begin
            slp_en_i = 1'(e); sstate_i = 3'(s);
            step();
            chk("R8 cpu_slp_n", cpu_slp_n_o, (e == 1 && s == 1) ? 0 : 1);
         end
      end
      slp_en_i = 1'b0; sstate_i = '0;

      // R6: sweep battery-low x S-state x wake request
      for (int b = 0; b < 2; b++) begin
         batt_low_i = 1'(b);
         step(SYNC_STAGES + 2);
         for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 2; w++) begin
               sstate_i = 3'(s); wake_req_i = 1'(w);
               step();
               chk("R6 wake", wake_o,
                   (w == 1 && !(b == 1 && s >= 3 && s <= 5)) ? 1 : 0);
            end
         end
      end
      wake_req_i = 1'b0; sstate_i = '0;
      batt_low_i = 1'b0;

      // R7: interrupt pulse timing, enabled then disabled
      for (int en = 1; en >= 0; en--) begin
         smi_en_i = 1'(en);
         batt_low_i = 1'b0;
         step(SYNC_STAGES + 3);
         batt_low_i = 1'b1;
         hits = 0; idx = 0;
         for (int i = 1; i <= 10; i++) begin
            step();
            if (smi_req_o) begin hits++; idx = i; end
         end
         chk("R7 smi count", hits, en);
         chk("R7 smi delay", idx, en ? SYNC_STAGES + 1 : 0);
      end
      batt_low_i = 1'b0; smi_en_i = 1'b0;
      step(4);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule